// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block serves one DRAM bank for a memory controller. It takes one read or write request at a time, each carrying a row and a column, and turns it into the bank commands that request needs: open a row (activate), read or write a column, and close the row (precharge). Column accesses are only ever served from the row that currently sits in the row buffer, so the block tracks whether a row is open and which one it is.

A run-time input selects the page policy. With the open-page policy the row stays in the buffer after the column access, so a later request to the same row is a hit and costs only the column command. A request to another row first closes the open one. With the close-page policy every access ends with a precharge, and the bank is idle again before the next request is taken. The policy is sampled when a request is accepted. Minimum command spacings are held by down-counters whose reload values are parameters: activate to activate, activate to column, precharge to activate, and write to read.

A one-cycle lookup result after each acceptance reports whether the request hit the open row. Together with the open-row outputs, it lets an upstream scheduler prefer hits.

Top module: `bank_rowbuf_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, no command is issued, no row is open, lookup_valid is low and req_ready is high. No spacing limit applies to the first command after reset, so a request accepted at edge n, with no row open, shows its activate in cycle n+1.
- R2: A read or write command is only issued for the row that is open at that time. A request to a closed bank first issues an activate of its row. cmd_kind encodes activate as 0, read as 1, write as 2 and precharge as 3.
- R3: Under the open-page policy (policy_close = 0), a request whose row is already open issues only its column command, and the row stays open afterwards.
- R4: Under the open-page policy, a request to a row other than the open one issues a precharge of the open row, then an activate of the new row, then the column command.
- R5: Under the close-page policy (policy_close = 1), a precharge follows in the cycle after the column command. No row is open after that precharge, and req_ready stays low from the acceptance until the cycle after that precharge.
- R6: Two activates are at least TRC cycles apart, counted between the cycles in which they appear.
- R7: A read command appears at least TWTR cycles after the most recent write command.
- R8: A column command appears at least TRCD cycles after the activate of its row, and an activate appears at least TRP cycles after the most recent precharge.
- R9: In the cycle after a request is accepted, lookup_valid is high for one cycle. In that cycle lookup_hit shows whether the request's row was the open row at acceptance.
- R10: open_valid and open_row change in the same cycle as the command that causes the change: an activate opens its row and a precharge closes the bank.
- R11: The policy applies per request. It is taken at acceptance, and a change of policy_close while a request is in progress affects only later requests.
- R12: Only one request is in progress at a time. req_ready is high exactly when no request is held, and a request is accepted at an edge where req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_close | input | 1 | 1 selects close-page, 0 selects open-page; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_ready | output | 1 | Block can accept a request |
| cmd_valid | output | 1 | A bank command is issued this cycle |
| cmd_kind | output | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_row | output | ROW_W | Row for activate and column commands; the closed row for precharge |
| cmd_col | output | COL_W | Column for read and write; zero otherwise |
| open_valid | output | 1 | A row is held in the row buffer |
| open_row | output | ROW_W | Row held in the row buffer |
| lookup_valid | output | 1 | One-cycle pulse after an acceptance |
| lookup_hit | output | 1 | The accepted request hit the open row |

## Verification
A wrong open-row record shows at the ports within a cycle or two. The block either issues a column command to a row that has no activate behind it, or it precharges and reopens a row that was already open. Either way cmd_kind or cmd_row differs from the reference model, and lookup_hit reports the wrong answer after the next acceptance. A spacing counter that reloads or decrements wrongly moves an activate or a read by a cycle or more, and the per-cycle comparison sees this at the first command that depends on that spacing. A lost or stuck in-progress flag shows at once as req_ready out of step with the model, or as a missing final precharge under the close-page policy.

// File: rtl/bank_rowbuf_pkg.sv
package bank_rowbuf_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } bank_cmd_e;

  // indices into the spacing-timer bank
  localparam int GAP_ACT2ACT = 0;
  localparam int GAP_ACT2COL = 1;
  localparam int GAP_PRE2ACT = 2;
  localparam int GAP_WR2RD   = 3;
  localparam int GAP_COUNT   = 4;

endpackage

// File: rtl/brb_gap_timer.sv
module brb_gap_timer #(
  parameter int unsigned GAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic clear
);
  localparam int CW = (GAP < 2) ? 1 : $clog2(GAP);
  localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign clear = (cnt_q == '0);
endmodule

// File: rtl/brb_row_tracker.sv
module brb_row_tracker #(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_open,
  input  logic [ROW_W-1:0] new_row,
  input  logic             do_close,
  input  logic [ROW_W-1:0] probe_a_row,
  input  logic [ROW_W-1:0] probe_b_row,
  output logic             probe_a_hit,
  output logic             probe_b_hit,
  output logic             held_valid,
  output logic [ROW_W-1:0] held_row
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_row   <= '0;
    end else if (do_open) begin
      held_valid <= 1'b1;
      held_row   <= new_row;
    end else if (do_close) begin
      held_valid <= 1'b0;
    end
  end

  assign probe_a_hit = held_valid && (held_row == probe_a_row);
  assign probe_b_hit = held_valid && (held_row == probe_b_row);
endmodule

// File: rtl/brb_cmd_sched.sv
module brb_cmd_sched
  import bank_rowbuf_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 policy_close,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic                 held_valid,
  input  logic [ROW_W-1:0]     held_row,
  input  logic                 req_hits,
  input  logic                 pend_hits,
  input  logic [GAP_COUNT-1:0] gap_clear,
  output logic [ROW_W-1:0]     pend_row,
  output logic                 go_act,
  output logic                 go_pre,
  output logic                 go_wr,
  output logic                 req_ready,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_kind,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic                 lookup_valid,
  output logic                 lookup_hit
);
  logic             busy_q;
  logic             tail_q;      // column done, closing precharge owed
  logic             p_write_q;
  logic             p_close_q;
  logic [COL_W-1:0] p_col_q;
  logic [ROW_W-1:0] p_row_q;

  logic take;
  logic go_col;
  logic busy_d;

  assign pend_row = p_row_q;
  assign take     = req_valid && !busy_q;

  always_comb begin
    go_act = 1'b0;
    go_pre = 1'b0;
    go_col = 1'b0;
    if (busy_q) begin
      if (tail_q) begin
        go_pre = 1'b1;
      end else if (pend_hits) begin
        go_col = gap_clear[GAP_ACT2COL] && (p_write_q || gap_clear[GAP_WR2RD]);
      end else if (held_valid) begin
        go_pre = 1'b1;
      end else begin
        go_act = gap_clear[GAP_ACT2ACT] && gap_clear[GAP_PRE2ACT];
      end
    end
  end

  assign go_wr = go_col && p_write_q;

  always_comb begin
    busy_d = busy_q;
    if (take) begin
      busy_d = 1'b1;
    end else if (go_col && !p_close_q) begin
      busy_d = 1'b0;
    end else if (go_pre && tail_q) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      tail_q    <= 1'b0;
      p_write_q <= 1'b0;
      p_close_q <= 1'b0;
      p_col_q   <= '0;
      p_row_q   <= '0;
      req_ready <= 1'b1;
    end else begin
      busy_q    <= busy_d;
      req_ready <= !busy_d;
      if (take) begin
        p_write_q <= req_write;
        p_close_q <= policy_close;
        p_col_q   <= req_col;
        p_row_q   <= req_row;
        tail_q    <= 1'b0;
      end else if (go_col && p_close_q) begin
        tail_q <= 1'b1;
      end else if (go_pre && tail_q) begin
        tail_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid    <= 1'b0;
      cmd_kind     <= CMD_ACT;
      cmd_row      <= '0;
      cmd_col      <= '0;
      lookup_valid <= 1'b0;
      lookup_hit   <= 1'b0;
    end else begin
      cmd_valid    <= go_act || go_pre || go_col;
      lookup_valid <= take;
      lookup_hit   <= take && req_hits;
      cmd_col      <= '0;
      if (go_act) begin
        cmd_kind <= CMD_ACT;
        cmd_row  <= p_row_q;
      end else if (go_pre) begin
        cmd_kind <= CMD_PRE;
        cmd_row  <= held_row;
      end else if (go_col) begin
        cmd_kind <= p_write_q ? CMD_WR : CMD_RD;
        cmd_row  <= p_row_q;
        cmd_col  <= p_col_q;
      end
    end
  end
endmodule

// File: rtl/bank_rowbuf_ctrl.sv
module bank_rowbuf_ctrl
  import bank_rowbuf_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TRC   = 10,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TWTR  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             policy_close,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             req_ready,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             open_valid,
  output logic [ROW_W-1:0] open_row,
  output logic             lookup_valid,
  output logic             lookup_hit
);
  localparam int unsigned GAP_TAB [GAP_COUNT] = '{TRC, TRCD, TRP, TWTR};

  logic [GAP_COUNT-1:0] gap_load;
  logic [GAP_COUNT-1:0] gap_clear;
  logic                 go_act, go_pre, go_wr;
  logic                 req_hits, pend_hits;
  logic [ROW_W-1:0]     pend_row;

  assign gap_load[GAP_ACT2ACT] = go_act;
  assign gap_load[GAP_ACT2COL] = go_act;
  assign gap_load[GAP_PRE2ACT] = go_pre;
  assign gap_load[GAP_WR2RD]   = go_wr;

  for (genvar g = 0; g < GAP_COUNT; g++) begin : g_gap
    brb_gap_timer #(.GAP(GAP_TAB[g])) u_timer (
      .clk   (clk),
      .rst   (rst),
      .load  (gap_load[g]),
      .clear (gap_clear[g])
    );
  end

  brb_row_tracker #(.ROW_W(ROW_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .do_open     (go_act),
    .new_row     (pend_row),
    .do_close    (go_pre),
    .probe_a_row (req_row),
    .probe_b_row (pend_row),
    .probe_a_hit (req_hits),
    .probe_b_hit (pend_hits),
    .held_valid  (open_valid),
    .held_row    (open_row)
  );

  brb_cmd_sched #(.ROW_W(ROW_W), .COL_W(COL_W)) u_sched (
    .clk          (clk),
    .rst          (rst),
    .policy_close (policy_close),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_row      (req_row),
    .req_col      (req_col),
    .held_valid   (open_valid),
    .held_row     (open_row),
    .req_hits     (req_hits),
    .pend_hits    (pend_hits),
    .gap_clear    (gap_clear),
    .pend_row     (pend_row),
    .go_act       (go_act),
    .go_pre       (go_pre),
    .go_wr        (go_wr),
    .req_ready    (req_ready),
    .cmd_valid    (cmd_valid),
    .cmd_kind     (cmd_kind),
    .cmd_row      (cmd_row),
    .cmd_col      (cmd_col),
    .lookup_valid (lookup_valid),
    .lookup_hit   (lookup_hit)
  );
endmodule

// File: rtl/bank_rowbuf_ctrl_chk.sv
module bank_rowbuf_ctrl_chk #(
  parameter int ROW_W = 14,
  parameter int TRC   = 10,
  parameter int TRCD  = 3,
  parameter int TWTR  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [ROW_W-1:0] cmd_row,
  input logic             open_valid,
  input logic [ROW_W-1:0] open_row,
  input logic             lookup_valid
);
  localparam logic [15:0] SAT = 16'hFFFF;

  logic        act_seen, wr_seen;
  logic [15:0] since_act, since_wr;
  logic        is_act, is_col, is_rd, is_wr, is_pre;

  assign is_act = cmd_valid && (cmd_kind == 2'd0);
  assign is_rd  = cmd_valid && (cmd_kind == 2'd1);
  assign is_wr  = cmd_valid && (cmd_kind == 2'd2);
  assign is_pre = cmd_valid && (cmd_kind == 2'd3);
  assign is_col = is_rd || is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_seen  <= 1'b0;
      wr_seen   <= 1'b0;
      since_act <= '0;
      since_wr  <= '0;
    end else begin
      if (is_act) begin
        act_seen  <= 1'b1;
        since_act <= 16'd1;
      end else if (since_act != SAT) begin
        since_act <= since_act + 16'd1;
      end
      if (is_wr) begin
        wr_seen  <= 1'b1;
        since_wr <= 16'd1;
      end else if (since_wr != SAT) begin
        since_wr <= since_wr + 16'd1;
      end
    end
  end

  // R2
  col_to_open_row_chk: assert property (@(posedge clk) disable iff (rst)
    is_col |-> (open_valid && open_row == cmd_row));

  // R10
  act_opens_row_chk: assert property (@(posedge clk) disable iff (rst)
    is_act |-> (open_valid && open_row == cmd_row));

  // R10
  pre_closes_row_chk: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> !open_valid);

  // R6
  act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    is_act |-> (!act_seen || since_act >= 16'(TRC)));

  // R8
  act_to_col_chk: assert property (@(posedge clk) disable iff (rst)
    is_col |-> (act_seen && since_act >= 16'(TRCD)));

  // R7
  write_to_read_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> (!wr_seen || since_wr >= 16'(TWTR)));

  // R12
  single_inflight_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  lookup_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> !lookup_valid);
endmodule

bind bank_rowbuf_ctrl bank_rowbuf_ctrl_chk #(
  .ROW_W(ROW_W), .TRC(TRC), .TRCD(TRCD), .TWTR(TWTR)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind),
  .cmd_row      (cmd_row),
  .open_valid   (open_valid),
  .open_row     (open_row),
  .lookup_valid (lookup_valid)
);

// File: tb/bank_rowbuf_ctrl_bench.sv
module bank_rowbuf_ctrl_bench;
  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int TRC   = 10;
  localparam int TRCD  = 3;
  localparam int TRP   = 3;
  localparam int TWTR  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             policy_close = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_ready, cmd_valid, open_valid, lookup_valid, lookup_hit;
  logic [1:0]       cmd_kind;
  logic [ROW_W-1:0] cmd_row, open_row;
  logic [COL_W-1:0] cmd_col;

  always #4 clk = ~clk;

  bank_rowbuf_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .TRC(TRC), .TRCD(TRCD), .TRP(TRP), .TWTR(TWTR)
  ) u_bank_rowbuf_ctrl (
    .clk(clk), .rst(rst), .policy_close(policy_close),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .open_valid(open_valid), .open_row(open_row),
    .lookup_valid(lookup_valid), .lookup_hit(lookup_hit)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";
  bit cmp_en = 0;

  // behavioural reference model
  int k, t_act, t_pre, t_wr;
  bit m_busy, m_tail, m_open, m_pw, m_pc;
  int m_orow, m_prow, m_pcol;
  bit e_cv, e_lv, e_lh, e_ready;
  int e_kind, e_row, e_col;

  task automatic model_reset();
    k = 0; t_act = -1000; t_pre = -1000; t_wr = -1000;
    m_busy = 0; m_tail = 0; m_open = 0; m_pw = 0; m_pc = 0;
    m_orow = 0; m_prow = 0; m_pcol = 0;
    e_cv = 0; e_lv = 0; e_lh = 0; e_ready = 1; e_kind = 0; e_row = 0; e_col = 0;
  endtask

  task automatic emit(input int kind, input int row, input int col);
    e_cv = 1; e_kind = kind; e_row = row; e_col = col;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      k++;
      e_cv = 0; e_lv = 0; e_lh = 0; e_col = 0;
      if (m_busy) begin
        if (m_tail) begin
          emit(3, m_orow, 0); m_open = 0; t_pre = k; m_tail = 0; m_busy = 0;
        end else if (m_open && m_orow == m_prow) begin
          if ((k - t_act >= TRCD) && (m_pw || (k - t_wr >= TWTR))) begin
            emit(m_pw ? 2 : 1, m_prow, m_pcol);
            if (m_pw) t_wr = k;
            if (m_pc) m_tail = 1; else m_busy = 0;
          end
        end else if (m_open) begin
          emit(3, m_orow, 0); m_open = 0; t_pre = k;
        end else if ((k - t_act >= TRC) && (k - t_pre >= TRP)) begin
          emit(0, m_prow, 0); m_open = 1; m_orow = m_prow; t_act = k;
        end
      end else if (req_valid) begin
        m_busy = 1; m_pw = req_write; m_pc = policy_close;
        m_prow = int'(req_row); m_pcol = int'(req_col);
        e_lv = 1; e_lh = m_open && (m_orow == int'(req_row));
      end
      e_ready = !m_busy;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      check(cmd_valid == e_cv, cur_tag, "cmd_valid", int'(cmd_valid), int'(e_cv));
      if (e_cv) begin
        check(int'(cmd_kind) == e_kind, cur_tag, "cmd_kind", int'(cmd_kind), e_kind);
        check(int'(cmd_row) == e_row, cur_tag, "cmd_row", int'(cmd_row), e_row);
        check(int'(cmd_col) == e_col, cur_tag, "cmd_col", int'(cmd_col), e_col);
      end
      check(open_valid == m_open, "R10", "open_valid", int'(open_valid), int'(m_open));
      if (m_open)
        check(int'(open_row) == m_orow, "R10", "open_row", int'(open_row), m_orow);
      check(req_ready == e_ready, "R12", "req_ready", int'(req_ready), int'(e_ready));
      check(lookup_valid == e_lv, "R9", "lookup_valid", int'(lookup_valid), int'(e_lv));
      if (e_lv)
        check(lookup_hit == e_lh, "R9", "lookup_hit", int'(lookup_hit), int'(e_lh));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", wd);
      summary();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input bit wr, input int row, input int col);
    @(negedge clk);
    req_valid = 1; req_write = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic reset_check(input int cycles);
    @(negedge clk);
    rst = 1;
    idle(cycles);
    rst = 0;
    @(negedge clk);
    // R1 reset state at the ports
    check(!cmd_valid, "R1", "cmd_valid after reset", int'(cmd_valid), 0);
    check(!open_valid, "R1", "open_valid after reset", int'(open_valid), 0);
    check(req_ready, "R1", "req_ready after reset", int'(req_ready), 1);
    check(!lookup_valid, "R1", "lookup_valid after reset", int'(lookup_valid), 0);
  endtask

  int lfsr = 32'h1ACE5;

  initial begin
    model_reset();
    @(posedge clk);
    cmp_en = 1;
    idle(3);
    cur_tag = "R1";
    reset_check(2);

    // R1: first activate right after acceptance with no gap pending
    @(negedge clk);
    req_valid = 1; req_write = 0; req_row = 14'd5; req_col = 10'd1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check(cmd_valid && cmd_kind == 2'd0, "R1", "first activate", int'(cmd_kind), 0);
    cur_tag = "R2";
    wait_idle();

    cur_tag = "R3";
    send(0, 5, 2);
    send(1, 5, 3);
    cur_tag = "R7";
    send(0, 5, 4);
    wait_idle();

    cur_tag = "R4";
    send(0, 9, 7);
    wait_idle();
    check(open_valid && open_row == 14'd9, "R4", "row after miss", int'(open_row), 9);

    cur_tag = "R6";
    send(1, 10, 1);
    send(0, 11, 2);
    send(0, 12, 3);
    wait_idle();

    cur_tag = "R5";
    policy_close = 1;
    send(1, 20, 5);
    send(0, 20, 6);
    send(0, 21, 7);
    wait_idle();
    check(!open_valid, "R5", "bank idle after close-page", int'(open_valid), 0);

    cur_tag = "R11";
    send(0, 22, 1);
    policy_close = 0;
    wait_idle();
    check(!open_valid, "R11", "policy held per request", int'(open_valid), 0);
    send(0, 23, 1);
    wait_idle();
    check(open_valid && open_row == 14'd23, "R11", "open-page after change",
          int'(open_row), 23);

    cur_tag = "R8";
    idle(12);
    send(1, 30, 2);
    send(0, 30, 3);
    wait_idle();

    cur_tag = "R1";
    reset_check(3);

    cur_tag = "R12";
    for (int i = 0; i < 120; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      policy_close = ((lfsr >> 5) & 7) == 0;
      send(lfsr[1], (lfsr >> 2) & 3, (lfsr >> 8) & 1023);
      if (lfsr[12]) idle(lfsr[14:13]);
    end
    wait_idle();
    idle(4);
    summary();
    $finish;
  end
endmodule